// File: doc/BRIEF.md
# GPIO Port with Edge and Level Interrupt Detection

A memory-mapped general-purpose I/O port of up to 32 pins. Software reaches it over a simple single-cycle register bus. For each pin it sets an output-enable bit, an input-enable bit and an output data bit. The port drives the pad output and the pad output enable from these registers. Pad inputs pass through a two-flop synchronizer. A sampling stage then takes them either on every clock or once every `SLOW_DIV` clocks, selected by a bit in the port control word.

Each pin has a 2-bit trigger type: rising edge, falling edge, high level or low level. There is no both-edges type. Software builds that behaviour by flipping the pin between rising and falling after each event. A detected event sets the pin's sticky pending bit, whatever the state of its mask bit. A per-pin mask bit lets that pending bit reach the single port interrupt. A port enable bit gates the interrupt as a whole. A port-level pending flag records that a masked pin has seen an event.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads zero, and `pad_o`, `pad_oe_o` and `irq_o` are 0.
- R2: Output enable (byte address 0x00) and input enable (0x04) are independent per-pin read/write bits. `pad_oe_o` follows the output-enable register and `pad_o` follows the data register (0x08) from the clock edge that writes them.
- R3: A read of the data register returns the sampled pad level for pins whose input enable is 1, and the written output bit for all other pins.
- R4: A pin's trigger type is the 2-bit field at bit (pin mod 16)*2. Pins 0–15 use register 0x10 and pins 16–31 use register 0x0C. The encoding is 00 rising edge, 01 falling edge, 10 high level, 11 low level.
- R5: When fast sampling is selected, a pad edge that matches the pin's edge type and is applied before clock edge 1 sets the pending bit at clock edge 4. It sets the bit once per edge.
- R6: A level-type pin's pending bit is set on every clock while its level holds. A clear written during that time does not leave it cleared.
- R7: The pending register (0x18) is write-one-to-clear. Writing 0 leaves a bit unchanged. Pending bits latch events even while the pin's mask bit is 0. A new event wins over a clear in the same cycle.
- R8: The mask register (0x14) enables a pin's interrupt with a 1. `irq_o` is 1 exactly when the port enable is 1 and some pin has both its mask bit and its pending bit set.
- R9: The control word (0x1C) holds a 5-bit slice at bit `PORT_IDX`*5. Slice bit 0 is the port pending flag, bit 1 the port enable and bit 2 the fast-sample select. The other bits read 0. The port pending flag is set when a pin with mask 1 detects an event, and it is cleared by writing 1 to it.
- R10: Writing the control word with the enable bit at 0 forces `irq_o` to 0 from the next clock, with masked pending bits still set.
- R11: When fast-sample is 0, the sampled pad value changes only once every `SLOW_DIV` clocks, on the phase of a free-running divider that starts at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, 0 when no read is made |
| pad_i | input | NPINS | Asynchronous pad inputs |
| pad_o | output | NPINS | Pad output values |
| pad_oe_o | output | NPINS | Pad output enables |
| irq_o | output | 1 | Port interrupt |

## Verification
The hardest cases to reach from the ports involve a race. One is a level pin whose condition is still true in the same cycle that software writes a clear to its pending bit. The other is an edge that arrives while the divider of the slow sampling mode is in an unknown phase. The stimulus holds a low-level pin at 0 while it clears the pending register. It times single pad edges against the four-stage input path in fast mode. It then repeats the edges in slow mode, where a reference model that runs every cycle tracks the divider phase. The enable and mask interplay is reached by arming masks on pins that are already pending and by clearing the port enable while they stay pending.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_HIGH = 2'b10,
    TRIG_LOW  = 2'b11
  } trig_e;

  localparam logic [7:0] OFS_OUTEN   = 8'h00;
  localparam logic [7:0] OFS_INEN    = 8'h04;
  localparam logic [7:0] OFS_DATA    = 8'h08;
  localparam logic [7:0] OFS_TYPE_HI = 8'h0C;  // pins 16..31
  localparam logic [7:0] OFS_TYPE_LO = 8'h10;  // pins 0..15
  localparam logic [7:0] OFS_MASK    = 8'h14;
  localparam logic [7:0] OFS_PEND    = 8'h18;
  localparam logic [7:0] OFS_CTL     = 8'h1C;

  localparam int CTL_SLICE_W = 5;
  localparam int CTL_PEND_B  = 0;
  localparam int CTL_EN_B    = 1;
  localparam int CTL_FAST_B  = 2;
endpackage

// File: rtl/gpio_in_sampler.sv
module gpio_in_sampler #(
  parameter int NPINS    = 32,
  parameter int SLOW_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fast_i,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] smp_o,
  output logic [NPINS-1:0] prv_o,
  output logic             vld_o
);
  localparam int DIV_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [NPINS-1:0] sync1_q, sync2_q;
  logic             tick;

  assign tick = fast_i | (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o <= '0;
      prv_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= tick;
      if (tick) begin
        smp_o <= sync2_q;
        prv_o <= smp_o;
      end
    end
  end

  // R11
  slow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(smp_o));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NPINS-1:0]   smp_i,
  input  logic [NPINS-1:0]   prv_i,
  input  logic               vld_i,
  input  logic [2*NPINS-1:0] trig_i,
  input  logic [NPINS-1:0]   clr_i,
  output logic [NPINS-1:0]   pend_o,
  output logic [NPINS-1:0]   hit_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    trig_e trig;
    assign trig = trig_e'(trig_i[2*g +: 2]);

    always_comb begin
      unique case (trig)
        TRIG_RISE: hit_o[g] = vld_i & smp_i[g] & ~prv_i[g];
        TRIG_FALL: hit_o[g] = vld_i & ~smp_i[g] & prv_i[g];
        TRIG_HIGH: hit_o[g] = smp_i[g];
        default:   hit_o[g] = ~smp_i[g];
      endcase
    end

    // a new event wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[g] <= 1'b0;
      else pend_o[g] <= (pend_o[g] & ~clr_i[g]) | hit_o[g];
    end

    // R7
    pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[g] && !clr_i[g]) |=> pend_o[g]);
    // R6
    level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig == TRIG_HIGH && smp_i[g]) |=> pend_o[g]);
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter int PORT_IDX = 0,
  parameter int SLOW_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [7:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] pad_o,
  output logic [NPINS-1:0] pad_oe_o,
  output logic             irq_o
);
  localparam int CTL_L = PORT_IDX * CTL_SLICE_W;

  logic [NPINS-1:0] outen_q, inen_q, dout_q, mask_q;
  logic [63:0]      trig_q;
  logic             en_q, fast_q, ppend_q;
  logic [NPINS-1:0] smp, prv, pend, hit, clr;
  logic             vld;
  logic             wr, rd;

  assign wr = bus_req_i & bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;
  assign clr = (wr && bus_addr_i == OFS_PEND) ? bus_wdata_i[NPINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outen_q <= '0;
      inen_q  <= '0;
      dout_q  <= '0;
      mask_q  <= '0;
      trig_q  <= '0;
      en_q    <= 1'b0;
      fast_q  <= 1'b0;
    end else if (wr) begin
      unique case (bus_addr_i)
        OFS_OUTEN:   outen_q <= bus_wdata_i[NPINS-1:0];
        OFS_INEN:    inen_q  <= bus_wdata_i[NPINS-1:0];
        OFS_DATA:    dout_q  <= bus_wdata_i[NPINS-1:0];
        OFS_TYPE_HI: trig_q[63:32] <= bus_wdata_i;
        OFS_TYPE_LO: trig_q[31:0]  <= bus_wdata_i;
        OFS_MASK:    mask_q  <= bus_wdata_i[NPINS-1:0];
        OFS_CTL: begin
          en_q   <= bus_wdata_i[CTL_L+CTL_EN_B];
          fast_q <= bus_wdata_i[CTL_L+CTL_FAST_B];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ppend_q <= 1'b0;
    else ppend_q <= (ppend_q & ~(wr && bus_addr_i == OFS_CTL && bus_wdata_i[CTL_L+CTL_PEND_B]))
                    | (|(hit & mask_q));
  end

  gpio_in_sampler #(.NPINS(NPINS), .SLOW_DIV(SLOW_DIV)) u_smp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fast_i(fast_q),
    .pad_i (pad_i),
    .smp_o (smp),
    .prv_o (prv),
    .vld_o (vld)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .smp_i (smp),
    .prv_i (prv),
    .vld_i (vld),
    .trig_i(trig_q[2*NPINS-1:0]),
    .clr_i (clr),
    .pend_o(pend),
    .hit_o (hit)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      unique case (bus_addr_i)
        OFS_OUTEN:   bus_rdata_o = 32'(outen_q);
        OFS_INEN:    bus_rdata_o = 32'(inen_q);
        OFS_DATA:    bus_rdata_o = 32'((smp & inen_q) | (dout_q & ~inen_q));
        OFS_TYPE_HI: bus_rdata_o = trig_q[63:32];
        OFS_TYPE_LO: bus_rdata_o = trig_q[31:0];
        OFS_MASK:    bus_rdata_o = 32'(mask_q);
        OFS_PEND:    bus_rdata_o = 32'(pend);
        OFS_CTL: begin
          bus_rdata_o[CTL_L+CTL_PEND_B] = ppend_q;
          bus_rdata_o[CTL_L+CTL_EN_B]   = en_q;
          bus_rdata_o[CTL_L+CTL_FAST_B] = fast_q;
        end
        default: ;
      endcase
    end
  end

  assign pad_o    = dout_q;
  assign pad_oe_o = outen_q;
  assign irq_o    = en_q & |(pend & mask_q);

  // R10
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == OFS_CTL && !bus_wdata_i[CTL_L+CTL_EN_B]) |=> !irq_o);
  // R2
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && bus_addr_i == OFS_OUTEN) |=> $stable(pad_oe_o));
  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (en_q && (|pend)));
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int SLOW_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad = '0;
  logic [31:0] pad_o, pad_oe;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_irq_port #(.NPINS(32), .PORT_IDX(0), .SLOW_DIV(SLOW_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_i(pad), .pad_o(pad_o), .pad_oe_o(pad_oe), .irq_o(irq));

  // reference model state
  bit [31:0] m_oe, m_ie, m_do, m_mask, m_pend, m_thi, m_tlo;
  bit        m_en, m_fast, m_pp, m_vld;
  bit [31:0] m_sync [2];
  bit [31:0] m_smp, m_prv;
  int        m_div;

  function automatic bit [1:0] m_type(int p);
    return (p < 16) ? m_tlo[(p%16)*2 +: 2] : m_thi[(p%16)*2 +: 2];
  endfunction

  function automatic bit [31:0] m_read(bit r, bit [7:0] a);
    if (!r) return 32'h0;
    case (a)
      8'h00: return m_oe;
      8'h04: return m_ie;
      8'h08: return (m_smp & m_ie) | (m_do & ~m_ie);
      8'h0C: return m_thi;
      8'h10: return m_tlo;
      8'h14: return m_mask;
      8'h18: return m_pend;
      8'h1C: return {29'd0, m_fast, m_en, m_pp};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_oe = 0; m_ie = 0; m_do = 0; m_mask = 0; m_pend = 0; m_thi = 0; m_tlo = 0;
      m_en = 0; m_fast = 0; m_pp = 0; m_vld = 0; m_sync[0] = 0; m_sync[1] = 0;
      m_smp = 0; m_prv = 0; m_div = 0;
    end else begin
      bit [31:0] h;
      bit [31:0] c;
      bit tk;
      for (int p = 0; p < 32; p++) begin
        case (m_type(p))
          2'd0: h[p] = m_vld && m_smp[p] && !m_prv[p];
          2'd1: h[p] = m_vld && !m_smp[p] && m_prv[p];
          2'd2: h[p] = m_smp[p];
          default: h[p] = !m_smp[p];
        endcase
      end
      c = (req && we && addr == 8'h18) ? wdata : 32'h0;
      m_pp = (m_pp && !(req && we && addr == 8'h1C && wdata[0])) || ((h & m_mask) != 0);
      m_pend = (m_pend & ~c) | h;
      tk = m_fast || (m_div == SLOW_DIV - 1);
      m_div = (m_div == SLOW_DIV - 1) ? 0 : m_div + 1;
      m_vld = tk;
      if (tk) begin m_prv = m_smp; m_smp = m_sync[1]; end
      m_sync[1] = m_sync[0];
      m_sync[0] = pad;
      if (req && we) begin
        case (addr)
          8'h00: m_oe = wdata;
          8'h04: m_ie = wdata;
          8'h08: m_do = wdata;
          8'h0C: m_thi = wdata;
          8'h10: m_tlo = wdata;
          8'h14: m_mask = wdata;
          8'h1C: begin m_en = wdata[1]; m_fast = wdata[2]; end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      tests++;
      if (pad_o !== m_do || pad_oe !== m_oe) begin
        fails++;
        $display("FAIL R2 cycle: pad_o=%h pad_oe=%h expected %h %h", pad_o, pad_oe, m_do, m_oe);
      end else if (irq !== (m_en && ((m_pend & m_mask) != 0))) begin
        fails++;
        $display("FAIL R8 cycle: irq=%b expected %b", irq, !irq);
      end else if (rdata !== m_read(req && !we, addr)) begin
        fails++;
        $display("FAIL R3 cycle: rdata=%h expected %h (addr %h)", rdata, m_read(req && !we, addr), addr);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
  endtask

  task automatic set_pad(logic [31:0] v);
    @(negedge clk);
    pad = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    check("R1 pad_oe", pad_oe, 0);
    check("R1 pad_o", pad_o, 0);
    check("R1 irq", {31'd0, irq}, 0);
    for (int a = 0; a < 8; a++) begin
      rd(8'(a * 4), v);
      check("R1 reg", v, 0);
    end

    // R2 enables and data
    wr(8'h00, 32'hA5A5_0F0F);
    rd(8'h00, v); check("R2 outen", v, 32'hA5A5_0F0F);
    check("R2 pad_oe", pad_oe, 32'hA5A5_0F0F);
    wr(8'h04, 32'h0000_FFFF);
    rd(8'h04, v); check("R2 inen", v, 32'h0000_FFFF);
    rd(8'h00, v); check("R2 outen kept", v, 32'hA5A5_0F0F);
    wr(8'h08, 32'h1234_5678);
    check("R2 pad_o", pad_o, 32'h1234_5678);

    // R3 data readback, fast sampling
    wr(8'h1C, 32'h4);
    set_pad(32'hFFFF_0000);
    repeat (6) @(posedge clk);
    rd(8'h08, v); check("R3 data mix a", v, 32'h1234_0000);
    set_pad(32'h0000_FFFF);
    repeat (6) @(posedge clk);
    rd(8'h08, v); check("R3 data mix b", v, 32'h1234_FFFF);

    // R4 type fields: pin3 falling, pin7 low, pin20 high
    wr(8'h10, 32'h0000_C040);
    wr(8'h0C, 32'h0000_0200);
    rd(8'h10, v); check("R4 type lo", v, 32'h0000_C040);
    rd(8'h0C, v); check("R4 type hi", v, 32'h0000_0200);
    set_pad(32'h0000_0008);
    repeat (6) @(posedge clk);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, v); check("R4 R6 only low-level pin7 pending", v, 32'h0000_0080);

    // R5 rising edge on pin5, exact latency
    set_pad(32'h0000_0028);
    repeat (3) @(posedge clk);
    rd(8'h18, v); check("R5 rise not yet", v, 32'h0000_0080);
    @(posedge clk);
    rd(8'h18, v); check("R5 rise set", v, 32'h0000_00A0);
    // R5 falling edge on pin3
    wr(8'h18, 32'h0000_00FF);
    set_pad(32'h0000_0020);
    repeat (3) @(posedge clk);
    rd(8'h18, v); check("R5 fall not yet", v, 32'h0000_0080);
    @(posedge clk);
    rd(8'h18, v); check("R5 fall set", v, 32'h0000_0088);
    repeat (4) @(posedge clk);
    rd(8'h18, v); check("R5 one event per edge", v, 32'h0000_0088);

    // R6 high level on pin20 survives clear
    set_pad(32'h0010_0020);
    repeat (6) @(posedge clk);
    wr(8'h18, 32'h0010_0000);
    rd(8'h18, v); check("R6 level re-sets", v & 32'h0010_0000, 32'h0010_0000);
    set_pad(32'h0000_0020);
    repeat (6) @(posedge clk);
    wr(8'h18, 32'h0010_0000);
    rd(8'h18, v); check("R6 cleared after level ends", v & 32'h0010_0000, 0);

    // R7 write zero, latch while masked
    wr(8'h18, 32'h0);
    rd(8'h18, v); check("R7 write zero keeps pin3", v & 32'h8, 32'h8);
    check("R7 no irq while masked", {31'd0, irq}, 0);

    // R8 mask and enable
    wr(8'h1C, 32'h6);
    check("R8 enable without mask", {31'd0, irq}, 0);
    wr(8'h14, 32'h8);
    check("R8 masked pending raises irq", {31'd0, irq}, 1);
    wr(8'h14, 32'h0);
    check("R8 mask off", {31'd0, irq}, 0);

    // R9 port pending flag
    wr(8'h1C, 32'h7);
    rd(8'h1C, v); check("R9 ctl cleared", v, 32'h6);
    wr(8'h14, 32'h80);
    rd(8'h1C, v); check("R9 port pending set", v, 32'h7);
    wr(8'h14, 32'h0);
    wr(8'h1C, 32'h7);
    rd(8'h1C, v); check("R9 port pending w1c", v, 32'h6);

    // R10 enable off drops irq
    wr(8'h14, 32'h8);
    check("R10 irq before", {31'd0, irq}, 1);
    wr(8'h1C, 32'h4);
    check("R10 irq after disable", {31'd0, irq}, 0);
    rd(8'h18, v); check("R10 pending kept", v & 32'h8, 32'h8);

    // R11 slow sampling
    wr(8'h1C, 32'h0);
    set_pad(32'h0);
    repeat (12) @(posedge clk);
    wr(8'h18, 32'hFFFF_FFFF);
    set_pad(32'h0000_0020);
    repeat (2) @(posedge clk);
    rd(8'h18, v); check("R11 slow not yet", v & 32'h20, 0);
    repeat (2 * SLOW_DIV + 4) @(posedge clk);
    rd(8'h18, v); check("R11 slow set", v & 32'h20, 32'h20);

    @(negedge clk) req = 0;
    repeat (3) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule